// File: doc/BRIEF.md
# Pseudo-Random Test Vector Generator (4-bit, maximal length)

This block is a four-flip-flop shift register with external XOR feedback. It steps through all fifteen non-zero 4-bit values in one fixed order and then repeats. It is meant to drive stimulus into logic under self-test: once reset, every enabled clock yields a fresh pattern on the registered output.

The bits are named s1 to s4 from left to right, with s1 on `vec_o[3]` and s4 on `vec_o[0]`. On each step the contents move one place toward s4, and s1 takes the XOR of the previous s3 and s4. The all-zero value would lock the register, so it is never allowed in. Reset starts the register at 0001, and a seed load of zero is replaced by 0001.

The inputs take effect in a fixed order of precedence: reset first, then seed load, then enable. When none of them is active, the register holds its value.

Top module: `lfsr_pattern_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `vec_o` becomes 0001 on that edge.
- R2: When `en` is high and `rst` and `load` are low, the next `vec_o` is {old[1]^old[0], old[3], old[2], old[1]}. Here bit 3 is s1 and bit 0 is s4.
- R3: Stepping from 0001, the states run 0001, 1000, 0100, 0010, 1001, 1100, 0110, 1011, 0101, 1010, 1101, 1110, 1111, 0111, 0011, and then return to 0001. The period is 15.
- R4: When `en`, `load` and `rst` are all low, `vec_o` keeps its value.
- R5: When `load` is high, `rst` is low and `seed_i` is non-zero, `vec_o` equals `seed_i` after the edge. This holds whatever the value of `en`.
- R6: When `load` is high, `rst` is low and `seed_i` is 0000, `vec_o` becomes 0001 after the edge.
- R7: Reset takes precedence over load, and load takes precedence over stepping.
- R8: After reset, `vec_o` is never 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 0001 |
| en | input | 1 | Advances the register by one step |
| load | input | 1 | Loads `seed_i`, with zero replaced by 0001 |
| seed_i | input | 4 | Seed value |
| vec_o | output | 4 | Registered pattern, bit 3 = s1 |

## Verification
Every non-zero seed is loaded and then stepped fifteen times. This checks each transition against the arithmetic rule and confirms that each orbit closes after exactly fifteen steps, which separates a maximal-length tap choice from a shorter cycle. A walk from 0001 is compared with the literal fifteen-state order, which exposes a reversed shift direction or wrong taps that still give period 15. Cycles with enable low, a zero seed, and load or reset applied together with other controls check the hold, the lockup guard and the precedence.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  localparam int unsigned LFSR_W = 4;
  typedef logic [LFSR_W-1:0] lfsr_t;
  localparam lfsr_t LFSR_START = lfsr_t'(1);
endpackage

// File: rtl/lfsr_feedback.sv
module lfsr_feedback
  import lfsr_pkg::*;
(
  input  lfsr_t cur_i,
  output lfsr_t nxt_o
);
  // Shift toward the rightmost bit (s4 = bit 0)
  for (genvar i = 0; i < LFSR_W - 1; i++) begin : g_shift
    assign nxt_o[i] = cur_i[i+1];
  end
  // New leftmost bit from the two rightmost old bits
  assign nxt_o[LFSR_W-1] = cur_i[1] ^ cur_i[0];
endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard
  import lfsr_pkg::*;
(
  input  lfsr_t seed_i,
  output lfsr_t safe_o
);
  always_comb begin
    if (seed_i == '0) safe_o = LFSR_START;
    else              safe_o = seed_i;
  end
endmodule

// File: rtl/lfsr_pattern_gen.sv
module lfsr_pattern_gen
  import lfsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed_i,
  output logic [LFSR_W-1:0] vec_o
);
  lfsr_t state_q;
  lfsr_t step_w;
  lfsr_t seed_w;

  lfsr_feedback u_fb (
    .cur_i (state_q),
    .nxt_o (step_w)
  );

  lfsr_seed_guard u_guard (
    .seed_i (seed_i),
    .safe_o (seed_w)
  );

  always_ff @(posedge clk) begin
    if (rst)       state_q <= LFSR_START;
    else if (load) state_q <= seed_w;
    else if (en)   state_q <= step_w;
  end

  assign vec_o = state_q;

  // R8
  never_zero_chk: assert property (@(posedge clk) disable iff (rst)
    vec_o != '0);

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(vec_o));

  // R5
  seed_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (load && seed_i != '0) |=> vec_o == $past(seed_i));

  // R6
  zero_seed_fix_chk: assert property (@(posedge clk) disable iff (rst)
    (load && seed_i == '0) |=> vec_o == LFSR_START);

  // R2
  shift_path_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> vec_o[LFSR_W-2:0] == $past(vec_o[LFSR_W-1:1]));
endmodule

// File: tb/lfsr_pattern_gen_tb.sv
module lfsr_pattern_gen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic load = 1'b0;
  logic [3:0] seed_i = 4'd0;
  logic [3:0] vec_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  lfsr_pattern_gen u_dut (.clk(clk), .rst(rst), .en(en), .load(load),
                          .seed_i(seed_i), .vec_o(vec_o));

  always #2.5 clk = ~clk;

  function automatic logic [3:0] model_step(logic [3:0] s);
    return {s[1] ^ s[0], s[3:1]};
  endfunction

  task automatic chk(input logic [3:0] exp, input string tag);
    n_chk++;
    if (vec_o !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, vec_o, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic e, input logic l, input logic [3:0] s);
    @(negedge clk);
    rst = r; en = e; load = l; seed_i = s;
    @(posedge clk);
    #1;
  endtask

  localparam logic [3:0] ORDER [15] = '{4'b0001, 4'b1000, 4'b0100, 4'b0010, 4'b1001,
    4'b1100, 4'b0110, 4'b1011, 4'b0101, 4'b1010, 4'b1101, 4'b1110, 4'b1111, 4'b0111, 4'b0011};

  initial begin
    logic [3:0] exp;
    cyc(1, 0, 0, 0);
    chk(4'b0001, "R1 reset value");
    // R3 literal order
    for (int k = 1; k <= 15; k++) begin
      cyc(0, 1, 0, 0);
      chk(ORDER[k % 15], "R3 sequence order");
    end
    // R2/R8 exhaustive over seeds
    for (int sd = 1; sd < 16; sd++) begin
      cyc(0, 0, 1, 4'(sd));
      chk(4'(sd), "R5 seed load");
      exp = 4'(sd);
      for (int k = 0; k < 15; k++) begin
        cyc(0, 1, 0, 4'(sd));
        exp = model_step(exp);
        chk(exp, "R2 step rule");
        n_chk++;
        if (vec_o == 4'd0) begin
          n_fail++;
          $display("FAIL R8: got %b expected nonzero", vec_o);
        end
      end
      chk(4'(sd), "R3 period 15");
    end
    // R4 hold
    cyc(0, 0, 1, 4'b1011);
    for (int k = 0; k < 3; k++) begin
      cyc(0, 0, 0, 4'b0110);
      chk(4'b1011, "R4 hold");
    end
    // R6 zero seed
    cyc(0, 0, 1, 4'b0000);
    chk(4'b0001, "R6 zero seed");
    cyc(0, 1, 1, 4'b0000);
    chk(4'b0001, "R6 zero seed with enable");
    // R5 load while enabled
    cyc(0, 1, 1, 4'b1110);
    chk(4'b1110, "R5 load ignores enable");
    // R7 precedence
    cyc(1, 1, 1, 4'b1010);
    chk(4'b0001, "R7 reset beats load");
    cyc(0, 1, 1, 4'b0101);
    chk(4'b0101, "R7 load beats step");
    cyc(0, 1, 0, 4'b0000);
    chk(4'b1010, "R7 step after load");
    cyc(1, 0, 0, 4'b0000);
    chk(4'b0001, "R1 reset mid-run");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule